// File: doc/BRIEF.md
# Indexed Configuration RAM Port

This block is the host-facing front end of a small battery-backed configuration memory. Software reaches every byte through two strobed ports. A write to the index port stores a byte address and a non-maskable-interrupt disable bit. Later strobes on the data port then read or write the byte at that stored address. The index stays in place between accesses, so repeated data-port operations all reach the same byte.

The block contains the general-purpose byte storage, which is 128 or 64 bytes deep depending on a parameter. It also drives the interrupt-mask output. The lowest fourteen locations (00h to 0Dh) are not stored here. They belong to an external timekeeping register file, and accesses to them go out on a separate request port. Two of those locations, 0Ch and 0Dh, are read-only, so data-port writes to them are dropped. In a 64-byte build, bit 6 of the index is ignored, so addresses 40h to 7Fh alias onto 00h to 3Fh, clock locations included.

A read is sequenced by a four-state machine:
- IDLE accepts host strobes.
- On a data read, IDLE goes to RAM_FETCH (the address is a storage location) or to CLOCK_FETCH (the address is a clock location).
- Both fetch states go on to RESPOND, where the byte is presented for one cycle.
- RESPOND then returns to IDLE.

Writes and index loads finish in IDLE in a single cycle. All strobes are ignored while a read is in flight.

Top module: `cmos_index_port`

## Requirements
- R1: While reset is asserted and after it is released: nmi_mask is 1, the stored index is 00h, and busy, rd_valid, rtc_wr and rtc_rd are all 0.
- R2: An idx_wr strobe accepted in IDLE loads wdata[6:0] as the byte address. The same strobe loads wdata[7] into nmi_mask, visible from the next cycle; 1 means the interrupt is disabled.
- R3: A data_wr strobe accepted in IDLE at an address of 0Eh or above stores wdata at that address. The index is left unchanged, so a second read or write reaches the same byte.
- R4: A data_rd strobe accepted in IDLE raises busy in the following cycle. In the second cycle after the strobe, rd_valid is 1 for exactly one cycle, with the byte on rdata. rdata is 00h whenever rd_valid is 0.
- R5: At an address of 00h to 0Dh (after aliasing), data_wr drives rtc_wr in the same cycle, with rtc_addr equal to the low 4 address bits and rtc_wdata equal to wdata. A data_rd at such an address drives rtc_rd for one cycle, in the cycle after the strobe. The value on rtc_rdata in that cycle is the value returned.
- R6: A data_wr at address 0Ch or 0Dh does not assert rtc_wr. A later read returns the clock file's unchanged value.
- R7: With DEPTH=64, index bit 6 is ignored. An access to 40h+n reaches the same byte or clock register as 00h+n.
- R8: While busy is 1, idx_wr, data_wr and data_rd are ignored. The index, nmi_mask and the stored bytes keep their values.
- R9: With DEPTH=128, addresses 40h to 7Fh are storage bytes distinct from 00h to 3Fh, and 40h to 4Dh do not reach the clock port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index port write strobe |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| wdata | input | 8 | Host write data for either port |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read completion pulse |
| busy | output | 1 | Read in flight; strobes ignored |
| nmi_mask | output | 1 | 1 = non-maskable interrupt disabled |
| rtc_addr | output | 4 | Clock register select |
| rtc_wr | output | 1 | Clock register write enable |
| rtc_rd | output | 1 | Clock register read request |
| rtc_wdata | output | 8 | Clock register write data |
| rtc_rdata | input | 8 | Clock register read data |

## Verification
The bench runs a 128-byte and a 64-byte instance side by side, with the same host stimulus, against a behavioural model. It aims at these corner cases:
- The 0Dh/0Eh boundary. A wrong split would send storage bytes to the clock port, or clock bytes into storage.
- The read-only slots 0Ch and 0Dh. A design that forwards writes there would corrupt the clock status values read back afterwards.
- The alias at 40h+n. In the small build, a missed alias would return a byte distinct from the one at 00h+n; in the large build, a wrong alias would overwrite the low byte.
- Strobes issued during a read. Accepting them would change the index, the interrupt mask or a stored byte.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAM_FETCH,
        ST_CLOCK_FETCH,
        ST_RESPOND
    } acc_state_t;

    localparam int unsigned IDX_W      = 7;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned RTC_SEL_W  = 4;
    localparam logic [6:0]  RTC_SPAN   = 7'h0E;
    localparam logic [6:0]  RO_STATUS0 = 7'h0C;
    localparam logic [6:0]  RO_STATUS1 = 7'h0D;

endpackage

// File: rtl/cmos_index_latch.sv
module cmos_index_latch
    import cmos_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] wdata,
    output logic [IDX_W-1:0]  index_q,
    output logic              nmi_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            nmi_q   <= 1'b1;
        end else if (load) begin
            index_q <= wdata[IDX_W-1:0];
            nmi_q   <= wdata[BYTE_W-1];
        end
    end

    assert_nmi_follows_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (nmi_q == $past(wdata[BYTE_W-1])));

    assert_index_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(index_q));

endmodule

// File: rtl/cmos_addr_map.sv
module cmos_addr_map
    import cmos_port_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic [IDX_W-1:0]         index,
    output logic [$clog2(DEPTH)-1:0] store_addr,
    output logic [RTC_SEL_W-1:0]     clock_sel,
    output logic                     is_clock,
    output logic                     is_readonly
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [IDX_W-1:0] phys;

    generate
        if (AW < IDX_W) begin : g_alias
            assign phys = {{(IDX_W-AW){1'b0}}, index[AW-1:0]};
        end else begin : g_full
            assign phys = index;
        end
    endgenerate

    assign store_addr  = phys[AW-1:0];
    assign clock_sel   = phys[RTC_SEL_W-1:0];
    assign is_clock    = (phys < RTC_SPAN);
    assign is_readonly = (phys == RO_STATUS0) || (phys == RO_STATUS1);

endmodule

// File: rtl/cmos_store.sv
module cmos_store
    import cmos_port_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        q
);

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            q <= cells[addr];
        end
    end

endmodule

// File: rtl/cmos_access_fsm.sv
module cmos_access_fsm
    import cmos_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              is_clock,
    input  logic              is_readonly,
    input  logic [BYTE_W-1:0] rtc_rdata,
    output logic              idx_load,
    output logic              store_we,
    output logic              store_re,
    output logic              rtc_wr,
    output logic              rtc_rd,
    output logic              busy,
    output logic              rd_valid,
    output logic              from_clock,
    output logic [BYTE_W-1:0] clock_q
);

    acc_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:        if (data_rd) state_nx = is_clock ? ST_CLOCK_FETCH : ST_RAM_FETCH;
            ST_RAM_FETCH:   state_nx = ST_RESPOND;
            ST_CLOCK_FETCH: state_nx = ST_RESPOND;
            ST_RESPOND:     state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idx_load = 1'b0;
        store_we = 1'b0;
        store_re = 1'b0;
        rtc_wr   = 1'b0;
        rtc_rd   = 1'b0;
        busy     = 1'b1;
        rd_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                idx_load = idx_wr;
                store_we = data_wr && !data_rd && !is_clock;
                rtc_wr   = data_wr && !data_rd && is_clock && !is_readonly;
            end
            ST_RAM_FETCH:   store_re = 1'b1;
            ST_CLOCK_FETCH: rtc_rd   = 1'b1;
            ST_RESPOND:     rd_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_clock <= 1'b0;
            clock_q    <= '0;
        end else if (state == ST_CLOCK_FETCH) begin
            from_clock <= 1'b1;
            clock_q    <= rtc_rdata;
        end else if (state == ST_RAM_FETCH) begin
            from_clock <= 1'b0;
        end
    end

    assert_single_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_read_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && data_rd) |=> busy);

    assert_clock_read_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_rd |=> (rd_valid && from_clock));

endmodule

// File: rtl/cmos_index_port.sv
module cmos_index_port
    import cmos_port_pkg::*;
#(
    parameter int unsigned DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rd_valid,
    output logic       busy,
    output logic       nmi_mask,
    output logic [3:0] rtc_addr,
    output logic       rtc_wr,
    output logic       rtc_rd,
    output logic [7:0] rtc_wdata,
    input  logic [7:0] rtc_rdata
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [IDX_W-1:0]  index_q;
    logic [AW-1:0]     store_addr;
    logic              is_clock;
    logic              is_readonly;
    logic              idx_load;
    logic              store_we;
    logic              store_re;
    logic              from_clock;
    logic [BYTE_W-1:0] clock_q;
    logic [BYTE_W-1:0] store_q;

    cmos_index_latch u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (idx_load),
        .wdata   (wdata),
        .index_q (index_q),
        .nmi_q   (nmi_mask)
    );

    cmos_addr_map #(.DEPTH(DEPTH)) u_map (
        .index       (index_q),
        .store_addr  (store_addr),
        .clock_sel   (rtc_addr),
        .is_clock    (is_clock),
        .is_readonly (is_readonly)
    );

    cmos_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_wr      (idx_wr),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .is_clock    (is_clock),
        .is_readonly (is_readonly),
        .rtc_rdata   (rtc_rdata),
        .idx_load    (idx_load),
        .store_we    (store_we),
        .store_re    (store_re),
        .rtc_wr      (rtc_wr),
        .rtc_rd      (rtc_rd),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .from_clock  (from_clock),
        .clock_q     (clock_q)
    );

    cmos_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (store_we),
        .re    (store_re),
        .addr  (store_addr),
        .wdata (wdata),
        .q     (store_q)
    );

    assign rtc_wdata = wdata;
    assign rdata     = rd_valid ? (from_clock ? clock_q : store_q) : '0;

    assert_reset_masks_nmi_R1: assert property (@(posedge clk)
        !rst_n |=> (nmi_mask && !busy && !rd_valid));

    assert_readonly_slots_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_wr |-> (rtc_addr != 4'hC && rtc_addr != 4'hD));

    assert_index_frozen_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(index_q) && $stable(nmi_mask)));

    assert_no_store_write_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!store_we && !rtc_wr));

endmodule

// File: tb/cmos_index_port_test.sv
module cmos_index_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;

    logic [7:0] rdata, rdata64;
    logic       rd_valid, rd_valid64, busy, busy64, nmi, nmi64;
    logic [3:0] rtc_addr, rtc_addr64;
    logic       rtc_wr, rtc_wr64, rtc_rd, rtc_rd64;
    logic [7:0] rtc_wdata, rtc_wdata64;
    logic [7:0] rtc_rdata;
    logic [7:0] rtc_file [16];

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] m128 [128];
    logic [7:0] m64 [64];
    logic [7:0] rtc_model [16];
    int         model_idx = 0;
    logic       model_nmi = 1'b1;

    always #10 clk = ~clk;

    cmos_index_port #(.DEPTH(128)) uut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy), .nmi_mask(nmi),
        .rtc_addr(rtc_addr), .rtc_wr(rtc_wr), .rtc_rd(rtc_rd), .rtc_wdata(rtc_wdata),
        .rtc_rdata(rtc_rdata)
    );

    cmos_index_port #(.DEPTH(64)) uut64 (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(wdata), .rdata(rdata64), .rd_valid(rd_valid64), .busy(busy64), .nmi_mask(nmi64),
        .rtc_addr(rtc_addr64), .rtc_wr(rtc_wr64), .rtc_rd(rtc_rd64), .rtc_wdata(rtc_wdata64),
        .rtc_rdata(8'h3C)
    );

    // external clock register file for the 128-byte instance
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rtc_file[i] <= 8'h80 + 8'(i);
        end else if (rtc_wr) begin
            rtc_file[rtc_addr] <= rtc_wdata;
        end
    end
    assign rtc_rdata = rtc_file[rtc_addr];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // every-cycle comparison of the interrupt mask against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R2 nmi_mask (128)", {7'd0, nmi}, {7'd0, model_nmi});
            chk("R2 nmi_mask (64)",  {7'd0, nmi64}, {7'd0, model_nmi});
        end
    end

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk);
        idx_wr = 1'b1; wdata = v;
        @(posedge clk);
        #1;
        model_idx = int'(v[6:0]);
        model_nmi = v[7];
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        int a, p;
        logic c128, c64;
        a = model_idx; p = a % 64;
        c128 = (a < 14) && (a != 12) && (a != 13);
        c64  = (p < 14) && (p != 12) && (p != 13);
        @(negedge clk);
        data_wr = 1'b1; wdata = v;
        #1;
        chk("R5/R6 rtc_wr (128)", {7'd0, rtc_wr}, {7'd0, c128});
        chk("R7 rtc_wr alias (64)", {7'd0, rtc_wr64}, {7'd0, c64});
        if (c128) begin
            chk("R5 rtc_addr", {4'd0, rtc_addr}, 8'(a));
            chk("R5 rtc_wdata", rtc_wdata, v);
        end
        if (c64) chk("R7 rtc_addr alias", {4'd0, rtc_addr64}, 8'(p));
        @(posedge clk);
        #1;
        if (a >= 14) m128[a] = v; else if (c128) rtc_model[a] = v;
        if (p >= 14) m64[p] = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic rd_data(input string req);
        int a, p;
        logic [7:0] e1, e2;
        a = model_idx; p = a % 64;
        e1 = (a < 14) ? rtc_model[a] : m128[a];
        e2 = (p < 14) ? 8'h3C : m64[p];
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk({req, " R4 busy"}, {7'd0, busy}, 8'd1);
        chk({req, " R5 rtc_rd"}, {7'd0, rtc_rd}, {7'd0, (a < 14)});
        chk({req, " R4 valid low"}, {7'd0, rd_valid}, 8'd0);
        @(negedge clk);
        chk({req, " R4 rd_valid"}, {7'd0, rd_valid}, 8'd1);
        chk({req, " rdata (128)"}, rdata, e1);
        chk({req, " rdata (64)"}, rdata64, e2);
        @(negedge clk);
        chk({req, " R4 pulse ends"}, {7'd0, rd_valid}, 8'd0);
        chk({req, " R4 rdata idle"}, rdata, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rtc_model[i] = 8'h80 + 8'(i);
        repeat (3) @(negedge clk);
        chk("R1 nmi_mask in reset", {7'd0, nmi}, 8'd1);
        chk("R1 busy in reset", {7'd0, busy}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 nmi_mask after reset", {7'd0, nmi}, 8'd1);
        chk("R1 rd_valid after reset", {7'd0, rd_valid}, 8'd0);
        chk("R1 rtc strobes", {6'd0, rtc_wr, rtc_rd}, 8'd0);
        chk("R1 index 00h reaches clock slot", {4'd0, rtc_addr}, 8'd0);

        // R2 / R3 / R4: storage write, repeated access at same index
        wr_idx(8'h20);
        wr_data(8'h5A);
        rd_data("R3 first read");
        rd_data("R3 repeat read");
        wr_data(8'h77);
        rd_data("R3 overwrite");
        wr_idx(8'h9F);
        wr_data(8'hC3);
        rd_data("R2 nmi set, addr 1Fh");

        // R5: clock-file access
        wr_idx(8'h05);
        wr_data(8'h42);
        rd_data("R5 clock read");
        // R6: read-only slots
        wr_idx(8'h0C);
        wr_data(8'hFF);
        rd_data("R6 slot 0Ch");
        wr_idx(8'h8D);
        wr_data(8'h11);
        rd_data("R6 slot 0Dh");

        // boundaries
        wr_idx(8'h0E);
        wr_data(8'h3E);
        rd_data("R3 first storage byte 0Eh");
        wr_idx(8'h7F);
        wr_data(8'hE7);
        rd_data("R9 top byte 7Fh");

        // R7 / R9: aliasing
        wr_idx(8'h10);
        wr_data(8'h11);
        wr_idx(8'h50);
        wr_data(8'h22);
        rd_data("R7/R9 read 50h");
        wr_idx(8'h10);
        rd_data("R7/R9 read 10h");
        wr_idx(8'h45);
        wr_data(8'h99);
        rd_data("R7/R9 read 45h");

        // R8: strobes during a read are dropped
        wr_idx(8'h30);
        wr_data(8'h31);
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0; data_wr = 1'b1; idx_wr = 1'b1; wdata = 8'hEE;
        @(negedge clk);
        data_wr = 1'b0; idx_wr = 1'b0;
        chk("R8 read completes", rdata, 8'h31);
        @(negedge clk);
        rd_data("R8 byte and index unchanged");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule